// File: doc/BRIEF.md
# Multithreaded Issue-Queue Entry Allocator

This block keeps the books for a shared instruction issue queue used by several hardware threads. It does not hold instructions and does no selection. It counts how many queue entries each thread occupies and how many entries remain free in the whole queue. It holds a per-thread occupancy limit and tells the dispatch stage, in the same cycle, whether a dispatch request can be accepted. Entries come back through issue slots, one completion port and one squash port, and each of these carries a thread number.

A build-time parameter selects how the queue is shared among threads. In the dynamic mode every thread may fill the whole queue. In the split mode the queue is divided evenly among the threads, with the quotient truncated. In the capped mode each thread may hold a fixed percentage of the queue, also truncated. An active-thread mask input tells the block which threads are running. When the number of running threads changes, the limits of the running threads are recomputed one cycle later. Instructions that touch memory keep their entry after they issue, and they give it back only on completion or squash.

Top module: `iq_entry_alloc`

## Requirements
- R1: After reset every thread occupancy is zero, glob_free equals ENTRIES, glob_full is low, and each thread's thr_free equals the limit that its policy sets for all NTHR threads running.
- R2: With POLICY = SHARE_DYNAMIC (code 0), every thread's limit is ENTRIES, whatever the active mask holds.
- R3: With POLICY = SHARE_SPLIT (code 1), each thread's limit after reset is ENTRIES / NTHR, truncated.
- R4: With POLICY = SHARE_CAP (code 2), each thread's limit after reset is ENTRIES * CAP_PCT / 100, truncated.
- R5: Under SHARE_SPLIT, when the number of set bits in active_mask changes to a nonzero value k, each thread whose mask bit is set gets limit ENTRIES / k, truncated, from the next cycle on. Threads whose bit is clear keep their limit. A mask of all zeros changes nothing.
- R6: Under SHARE_CAP, when the active count changes to exactly 1, the single active thread's limit becomes ENTRIES. When the count changes to any other nonzero value, each active thread's limit returns to the capped value.
- R7: An accepted dispatch lowers glob_free by one and raises the target thread's occupancy by one at the next clock edge.
- R8: disp_err rises in the same cycle as disp_valid when the target thread's thr_free is zero or glob_free is zero. A rejected dispatch changes no counter.
- R9: Each valid issue slot with iss_mem = 0 releases one entry of its thread at the next edge. A slot with iss_mem = 1 releases nothing.
- R10: A valid completion releases one entry of cmp_tid at the next edge.
- R11: A valid squash releases sq_cnt entries of sq_tid at the next edge.
- R12: All releases of one cycle (every issue slot, the completion and the squash) are summed together with any accepted dispatch before the counters update. glob_free always equals ENTRIES minus the sum of the thread occupancies.
- R13: thr_free of thread t is field t of thr_free (bits t*CW upward, CW = $clog2(ENTRIES+1)). It is the limit minus the occupancy, and it is zero when the occupancy is at or above the limit (for example after the limit shrinks). thr_full[t] is set exactly when that field is zero, and glob_full is set exactly when glob_free is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| active_mask | input | NTHR | One bit per running thread |
| disp_valid | input | 1 | Dispatch request this cycle |
| disp_tid | input | TW | Thread of the dispatch request |
| disp_err | output | 1 | Dispatch request rejected (combinational) |
| iss_valid | input | ISSUE_W | Issue slot valid bits |
| iss_tid | input | ISSUE_W*TW | Thread of each issue slot, slot s at bits s*TW |
| iss_mem | input | ISSUE_W | Issue slot carries a memory instruction |
| cmp_valid | input | 1 | Memory instruction completion |
| cmp_tid | input | TW | Thread of the completion |
| sq_valid | input | 1 | Squash release this cycle |
| sq_tid | input | TW | Thread being squashed |
| sq_cnt | input | CW | Entries released by the squash |
| glob_free | output | CW | Free entries in the whole queue |
| glob_full | output | 1 | Whole queue is full |
| thr_free | output | NTHR*CW | Per-thread free entries, thread t at bits t*CW |
| thr_full | output | NTHR | Per-thread full flags |

## Verification
In the same cycle, a dispatch can land on a thread while issue slots, a completion and a squash all release entries of that thread or of others. The dispatch decision must use the state from before those releases, and the counters must apply the net change. The bench provokes this with constrained random cycles that fire every release port together with a dispatch. The releases are drawn so that they never exceed the smallest occupancy held by any of three instances, one for each policy, and all three share the inputs. Each cycle the bench's own model predicts disp_err, every free count and every full flag, and it compares them with the ports. A second overlap is a change of the active mask that shrinks a limit below a thread's occupancy. Directed cases check that this saturates thr_free at zero and rejects further dispatches.

// File: rtl/iq_alloc_pkg.sv
package iq_alloc_pkg;

    // Sharing policy codes; values are part of the block's parameter contract.
    typedef enum logic [1:0] {
        SHARE_DYNAMIC = 2'd0,
        SHARE_SPLIT   = 2'd1,
        SHARE_CAP     = 2'd2
    } share_pol_e;

endpackage

// File: rtl/iq_release_sum.sv
module iq_release_sum #(
    parameter int NTHR    = 4,
    parameter int ISSUE_W = 2,
    parameter int TW      = 2,
    parameter int CW      = 6,
    parameter int RW      = 6
) (
    input  logic [ISSUE_W-1:0]        iss_valid,
    input  logic [ISSUE_W*TW-1:0]     iss_tid,
    input  logic [ISSUE_W-1:0]        iss_mem,
    input  logic                      cmp_valid,
    input  logic [TW-1:0]             cmp_tid,
    input  logic                      sq_valid,
    input  logic [TW-1:0]             sq_tid,
    input  logic [CW-1:0]             sq_cnt,
    output logic [NTHR-1:0][RW-1:0]   rel_thr,
    output logic [RW-1:0]             rel_total
);

    // Per-thread sum of every release source seen this cycle.
    always_comb begin
        rel_thr   = '0;
        rel_total = '0;
        for (int s = 0; s < ISSUE_W; s++) begin
            if (iss_valid[s] && !iss_mem[s]) begin
                rel_thr[iss_tid[s*TW +: TW]] = rel_thr[iss_tid[s*TW +: TW]] + RW'(1);
            end
        end
        if (cmp_valid) begin
            rel_thr[cmp_tid] = rel_thr[cmp_tid] + RW'(1);
        end
        if (sq_valid) begin
            rel_thr[sq_tid] = rel_thr[sq_tid] + RW'(sq_cnt);
        end
        for (int t = 0; t < NTHR; t++) begin
            rel_total = rel_total + rel_thr[t];
        end
    end

endmodule

// File: rtl/iq_limit_calc.sv
module iq_limit_calc
    import iq_alloc_pkg::*;
#(
    parameter share_pol_e POLICY  = SHARE_SPLIT,
    parameter int         ENTRIES = 32,
    parameter int         NTHR    = 4,
    parameter int         CAP_PCT = 50,
    parameter int         CW      = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NTHR-1:0]          active_mask,
    output logic [NTHR-1:0][CW-1:0]  lim
);

    localparam int AW       = $clog2(NTHR + 1);
    localparam int CAP_LIM  = (ENTRIES * CAP_PCT) / 100;
    localparam int INIT_LIM = (POLICY == SHARE_DYNAMIC) ? ENTRIES :
                              (POLICY == SHARE_SPLIT)   ? (ENTRIES / NTHR) : CAP_LIM;

    typedef struct packed {
        logic [AW-1:0]            cnt;
        logic [NTHR-1:0][CW-1:0]  lim;
    } lim_st_t;

    lim_st_t       st_d, st_q;
    logic [AW-1:0] cnt_now;

    function automatic logic [CW-1:0] split_of(input logic [AW-1:0] k);
        logic [CW-1:0] r;
        r = CW'(ENTRIES);
        for (int j = 1; j <= NTHR; j++) begin
            if (k == AW'(j)) r = CW'(ENTRIES / j);
        end
        return r;
    endfunction

    always_comb begin
        st_d    = st_q;
        cnt_now = AW'($countones(active_mask));
        if (cnt_now != '0 && cnt_now != st_q.cnt) begin
            st_d.cnt = cnt_now;
            for (int t = 0; t < NTHR; t++) begin
                if (active_mask[t]) begin
                    if (POLICY == SHARE_SPLIT) begin
                        st_d.lim[t] = split_of(cnt_now);
                    end else if (POLICY == SHARE_CAP) begin
                        st_d.lim[t] = (cnt_now == AW'(1)) ? CW'(ENTRIES) : CW'(CAP_LIM);
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cnt <= AW'(NTHR);
            for (int t = 0; t < NTHR; t++) st_q.lim[t] <= CW'(INIT_LIM);
        end else begin
            st_q <= st_d;
        end
    end

    assign lim = st_q.lim;

    generate
        for (genvar g = 0; g < NTHR; g++) begin : g_lim_chk
            if (POLICY == SHARE_DYNAMIC) begin : g_dyn
                // R2
                dyn_lim_chk: assert property (@(posedge clk) disable iff (!rst_n)
                    st_q.lim[g] == CW'(ENTRIES));
            end else if (POLICY == SHARE_SPLIT) begin : g_split
                // R5
                split_lim_chk: assert property (@(posedge clk) disable iff (!rst_n)
                    (cnt_now != '0 && cnt_now != st_q.cnt && active_mask[g])
                    |=> st_q.lim[g] == CW'(ENTRIES / int'($past(cnt_now))));
            end else begin : g_cap
                // R6
                cap_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
                    (cnt_now == AW'(1) && st_q.cnt != AW'(1) && active_mask[g])
                    |=> st_q.lim[g] == CW'(ENTRIES));
            end
        end
    endgenerate

endmodule

// File: rtl/iq_entry_alloc.sv
module iq_entry_alloc
    import iq_alloc_pkg::*;
#(
    parameter share_pol_e POLICY  = SHARE_SPLIT,
    parameter int         ENTRIES = 32,
    parameter int         NTHR    = 4,
    parameter int         ISSUE_W = 2,
    parameter int         CAP_PCT = 50,
    localparam int        CW      = $clog2(ENTRIES + 1),
    localparam int        TW      = (NTHR > 1) ? $clog2(NTHR) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NTHR-1:0]       active_mask,
    input  logic                  disp_valid,
    input  logic [TW-1:0]         disp_tid,
    output logic                  disp_err,
    input  logic [ISSUE_W-1:0]    iss_valid,
    input  logic [ISSUE_W*TW-1:0] iss_tid,
    input  logic [ISSUE_W-1:0]    iss_mem,
    input  logic                  cmp_valid,
    input  logic [TW-1:0]         cmp_tid,
    input  logic                  sq_valid,
    input  logic [TW-1:0]         sq_tid,
    input  logic [CW-1:0]         sq_cnt,
    output logic [CW-1:0]         glob_free,
    output logic                  glob_full,
    output logic [NTHR*CW-1:0]    thr_free,
    output logic [NTHR-1:0]       thr_full
);

    localparam int RW = $clog2(ENTRIES + ISSUE_W + 2);

    typedef struct packed {
        logic [NTHR-1:0][CW-1:0] occ;
        logic [CW-1:0]           gfree;
    } cnt_st_t;

    cnt_st_t                 st_d, st_q;
    logic [NTHR-1:0][CW-1:0] lim;
    logic [NTHR-1:0][RW-1:0] rel_thr;
    logic [RW-1:0]           rel_total;
    logic [NTHR-1:0][CW-1:0] free_t;
    logic                    disp_ok;

    iq_limit_calc #(
        .POLICY(POLICY), .ENTRIES(ENTRIES), .NTHR(NTHR), .CAP_PCT(CAP_PCT), .CW(CW)
    ) i_limit (
        .clk(clk), .rst_n(rst_n), .active_mask(active_mask), .lim(lim)
    );

    iq_release_sum #(
        .NTHR(NTHR), .ISSUE_W(ISSUE_W), .TW(TW), .CW(CW), .RW(RW)
    ) i_release (
        .iss_valid(iss_valid), .iss_tid(iss_tid), .iss_mem(iss_mem),
        .cmp_valid(cmp_valid), .cmp_tid(cmp_tid),
        .sq_valid(sq_valid), .sq_tid(sq_tid), .sq_cnt(sq_cnt),
        .rel_thr(rel_thr), .rel_total(rel_total)
    );

    always_comb begin
        for (int t = 0; t < NTHR; t++) begin
            free_t[t]            = (lim[t] > st_q.occ[t]) ? (lim[t] - st_q.occ[t]) : '0;
            thr_full[t]          = (free_t[t] == '0);
            thr_free[t*CW +: CW] = free_t[t];
        end
        glob_full = (st_q.gfree == '0);
        glob_free = st_q.gfree;
        disp_ok   = disp_valid && !thr_full[disp_tid] && !glob_full;
        disp_err  = disp_valid && !disp_ok;

        st_d = st_q;
        for (int t = 0; t < NTHR; t++) begin
            st_d.occ[t] = st_q.occ[t] - CW'(rel_thr[t])
                        + ((disp_ok && disp_tid == TW'(t)) ? CW'(1) : CW'(0));
        end
        st_d.gfree = st_q.gfree + CW'(rel_total) - (disp_ok ? CW'(1) : CW'(0));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.occ   <= '0;
            st_q.gfree <= CW'(ENTRIES);
        end else begin
            st_q <= st_d;
        end
    end

    // Checker helpers
    int   occ_sum;
    logic rel_bad;
    always_comb begin
        occ_sum = 0;
        rel_bad = 1'b0;
        for (int t = 0; t < NTHR; t++) begin
            occ_sum = occ_sum + int'(st_q.occ[t]);
            if (rel_thr[t] > RW'(st_q.occ[t])) rel_bad = 1'b1;
        end
    end

    // R12
    glob_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(st_q.gfree) == ENTRIES - occ_sum);

    // R8
    rej_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_err && rel_total == '0) |=> $stable(st_q.gfree));

    // R7
    take_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_valid && !disp_err && rel_total == '0) |=> st_q.gfree == $past(st_q.gfree) - CW'(1));

    // R11
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rel_bad);

endmodule

// File: tb/test_iq_entry_alloc.sv
`timescale 1ns/1ps
module test_iq_entry_alloc;
    import iq_alloc_pkg::*;

    localparam int N   = 14;
    localparam int NT  = 4;
    localparam int IW  = 2;
    localparam int PCT = 40;
    localparam int CW  = $clog2(N + 1);
    localparam int TW  = 2;
    localparam int CAPL = (N * PCT) / 100;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic [NT-1:0]    mask;
    logic             dv;
    logic [TW-1:0]    dtid;
    logic [IW-1:0]    iv;
    logic [IW*TW-1:0] itid;
    logic [IW-1:0]    imem;
    logic             cv;
    logic [TW-1:0]    ctid;
    logic             sv;
    logic [TW-1:0]    stid;
    logic [CW-1:0]    scnt;

    logic             derr  [3];
    logic [CW-1:0]    gfree [3];
    logic             gfull [3];
    logic [NT*CW-1:0] tfree [3];
    logic [NT-1:0]    tfull [3];

    iq_entry_alloc #(.POLICY(SHARE_DYNAMIC), .ENTRIES(N), .NTHR(NT), .ISSUE_W(IW), .CAP_PCT(PCT))
    i_iq_entry_alloc_dyn (
        .clk(clk), .rst_n(rst_n), .active_mask(mask), .disp_valid(dv), .disp_tid(dtid),
        .disp_err(derr[0]), .iss_valid(iv), .iss_tid(itid), .iss_mem(imem),
        .cmp_valid(cv), .cmp_tid(ctid), .sq_valid(sv), .sq_tid(stid), .sq_cnt(scnt),
        .glob_free(gfree[0]), .glob_full(gfull[0]), .thr_free(tfree[0]), .thr_full(tfull[0]));

    iq_entry_alloc #(.POLICY(SHARE_SPLIT), .ENTRIES(N), .NTHR(NT), .ISSUE_W(IW), .CAP_PCT(PCT))
    i_iq_entry_alloc (
        .clk(clk), .rst_n(rst_n), .active_mask(mask), .disp_valid(dv), .disp_tid(dtid),
        .disp_err(derr[1]), .iss_valid(iv), .iss_tid(itid), .iss_mem(imem),
        .cmp_valid(cv), .cmp_tid(ctid), .sq_valid(sv), .sq_tid(stid), .sq_cnt(scnt),
        .glob_free(gfree[1]), .glob_full(gfull[1]), .thr_free(tfree[1]), .thr_full(tfull[1]));

    iq_entry_alloc #(.POLICY(SHARE_CAP), .ENTRIES(N), .NTHR(NT), .ISSUE_W(IW), .CAP_PCT(PCT))
    i_iq_entry_alloc_cap (
        .clk(clk), .rst_n(rst_n), .active_mask(mask), .disp_valid(dv), .disp_tid(dtid),
        .disp_err(derr[2]), .iss_valid(iv), .iss_tid(itid), .iss_mem(imem),
        .cmp_valid(cv), .cmp_tid(ctid), .sq_valid(sv), .sq_tid(stid), .sq_cnt(scnt),
        .glob_free(gfree[2]), .glob_full(gfull[2]), .thr_free(tfree[2]), .thr_full(tfull[2]));

    // Bench model: index 0 dynamic, 1 split, 2 capped
    int occ_m [3][NT];
    int lim_m [3][NT];
    int gf_m  [3];
    int cnt_m [3];
    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int free_of(input int i, input int t);
        return (lim_m[i][t] > occ_m[i][t]) ? lim_m[i][t] - occ_m[i][t] : 0;
    endfunction

    function automatic int tf(input int i, input int t);
        return int'(tfree[i][t*CW +: CW]);
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 3; i++) begin
            gf_m[i] = N;
            cnt_m[i] = NT;
            for (int t = 0; t < NT; t++) begin
                occ_m[i][t] = 0;
                lim_m[i][t] = (i == 0) ? N : (i == 1) ? N / NT : CAPL;
            end
        end
    endtask

    task automatic check_all(input string tag);
        for (int i = 0; i < 3; i++) begin
            int exp_err;
            exp_err = (dv && (free_of(i, int'(dtid)) == 0 || gf_m[i] == 0)) ? 1 : 0;
            chk(int'(derr[i]) == exp_err, tag, int'(derr[i]), exp_err);
            chk(int'(gfree[i]) == gf_m[i], tag, int'(gfree[i]), gf_m[i]);
            chk(int'(gfull[i]) == ((gf_m[i] == 0) ? 1 : 0), tag, int'(gfull[i]), (gf_m[i] == 0) ? 1 : 0);
            for (int t = 0; t < NT; t++) begin
                chk(tf(i, t) == free_of(i, t), tag, tf(i, t), free_of(i, t));
                chk(int'(tfull[i][t]) == ((free_of(i, t) == 0) ? 1 : 0), tag,
                    int'(tfull[i][t]), (free_of(i, t) == 0) ? 1 : 0);
            end
        end
    endtask

    task automatic model_step();
        int rel [NT];
        int c;
        for (int t = 0; t < NT; t++) rel[t] = 0;
        for (int s = 0; s < IW; s++)
            if (iv[s] && !imem[s]) rel[int'(itid[s*TW +: TW])]++;
        if (cv) rel[int'(ctid)]++;
        if (sv) rel[int'(stid)] += int'(scnt);
        c = $countones(mask);
        for (int i = 0; i < 3; i++) begin
            bit ok;
            ok = dv && free_of(i, int'(dtid)) > 0 && gf_m[i] > 0;
            for (int t = 0; t < NT; t++) begin
                occ_m[i][t] += rel[t] - ((ok && int'(dtid) == t) ? 1 : 0) * -1;
                gf_m[i] += rel[t];
            end
            if (ok) gf_m[i]--;
            if (c != 0 && c != cnt_m[i]) begin
                cnt_m[i] = c;
                for (int t = 0; t < NT; t++) begin
                    if (mask[t]) begin
                        if (i == 1) lim_m[i][t] = N / c;
                        else if (i == 2) lim_m[i][t] = (c == 1) ? N : CAPL;
                    end
                end
            end
        end
        // occupancy decreases by releases: fix sign applied above
        for (int i = 0; i < 3; i++)
            for (int t = 0; t < NT; t++) occ_m[i][t] -= 2 * rel[t];
    endtask

    task automatic idle();
        dv = 1'b0; dtid = '0; iv = '0; itid = '0; imem = '0;
        cv = 1'b0; ctid = '0; sv = 1'b0; stid = '0; scnt = '0;
    endtask

    // Called at a falling edge after inputs are driven.
    task automatic tick(input string tag);
        #1;
        check_all(tag);
        model_step();
        @(negedge clk);
    endtask

    task automatic dispatch(input int t, input string tag);
        idle(); dv = 1'b1; dtid = TW'(t);
        tick(tag);
    endtask

    function automatic int min_occ(input int t);
        int m;
        m = occ_m[0][t];
        for (int i = 1; i < 3; i++) if (occ_m[i][t] < m) m = occ_m[i][t];
        return m;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = 32'h5eed_1234;
        void'($urandom(seed));
        mask = '1;
        idle();
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        tick("R1");
        // R2, R3, R4: initial limits per policy
        chk(tf(0, 0) == 14, "R2", tf(0, 0), 14);
        chk(tf(1, 0) == 3,  "R3", tf(1, 0), 3);
        chk(tf(2, 0) == 5,  "R4", tf(2, 0), 5);

        // R5: three active threads
        idle(); mask = 4'b0111; tick("R5");
        chk(tf(1, 0) == 4, "R5", tf(1, 0), 4);
        chk(tf(1, 3) == 3, "R5", tf(1, 3), 3);
        chk(tf(0, 2) == 14, "R2", tf(0, 2), 14);
        idle(); mask = 4'b0000; tick("R5");
        chk(tf(1, 0) == 4, "R5", tf(1, 0), 4);

        // R6: single active thread, then two
        idle(); mask = 4'b0001; tick("R6");
        chk(tf(2, 0) == 14, "R6", tf(2, 0), 14);
        chk(tf(2, 1) == 5,  "R6", tf(2, 1), 5);
        chk(tf(1, 0) == 14, "R5", tf(1, 0), 14);
        idle(); mask = 4'b0011; tick("R6");
        chk(tf(2, 0) == 5, "R6", tf(2, 0), 5);
        chk(tf(1, 1) == 7, "R5", tf(1, 1), 7);
        idle(); mask = 4'b1111; tick("R6");
        chk(tf(1, 0) == 3, "R5", tf(1, 0), 3);

        // R7: accepted dispatches
        dispatch(1, "R7");
        dispatch(1, "R7");
        chk(int'(gfree[1]) == 12, "R7", int'(gfree[1]), 12);
        chk(tf(1, 1) == 1, "R7", tf(1, 1), 1);

        // R8: fill thread 1, split rejects after 3, cap after 5
        for (int k = 0; k < 4; k++) dispatch(1, "R8");
        chk(int'(gfree[1]) == 11, "R8", int'(gfree[1]), 11);
        chk(int'(gfree[2]) == 9,  "R8", int'(gfree[2]), 9);

        // R9: non-memory issue releases, memory issue does not
        idle(); iv = 2'b11; itid = {2'd1, 2'd1}; imem = 2'b10; tick("R9");
        chk(int'(gfree[1]) == 12, "R9", int'(gfree[1]), 12);
        idle(); iv = 2'b01; itid = {2'd0, 2'd1}; imem = 2'b01; tick("R9");
        chk(int'(gfree[1]) == 12, "R9", int'(gfree[1]), 12);

        // R10: completion
        idle(); cv = 1'b1; ctid = 2'd1; tick("R10");
        chk(int'(gfree[1]) == 13, "R10", int'(gfree[1]), 13);

        // R11: squash releases a count
        idle(); sv = 1'b1; stid = 2'd1; scnt = CW'(min_occ(1)); tick("R11");
        chk(int'(gfree[1]) == 14, "R11", int'(gfree[1]), 14);

        // R13: limit shrinks below occupancy
        idle(); mask = 4'b0001; tick("R13");
        for (int k = 0; k < 6; k++) dispatch(0, "R13");
        idle(); mask = 4'b1111; tick("R13");
        chk(tf(1, 0) == 0 && tfull[1][0], "R13", tf(1, 0), 0);
        chk(tf(2, 0) == 0 && tfull[2][0], "R13", tf(2, 0), 0);
        dispatch(0, "R8");
        idle(); sv = 1'b1; stid = 2'd0; scnt = CW'(min_occ(0)); tick("R11");

        // R13: global full on the dynamic instance
        for (int k = 0; k < 15; k++) dispatch(k % NT, "R13");
        chk(gfull[0] == 1'b1, "R13", int'(gfull[0]), 1);
        for (int t = 0; t < NT; t++) begin
            idle(); sv = 1'b1; stid = TW'(t); scnt = CW'(min_occ(t)); tick("R11");
        end

        // R12: random overlapping releases and dispatches
        for (int n = 0; n < 3000; n++) begin
            int avail [NT];
            idle();
            for (int t = 0; t < NT; t++) avail[t] = min_occ(t);
            if ($urandom % 40 == 0) mask = NT'($urandom);
            dv = ($urandom % 3) != 0;
            dtid = TW'($urandom);
            for (int s = 0; s < IW; s++) begin
                int t;
                t = int'($urandom % NT);
                if ($urandom % 2 == 0) begin
                    if ($urandom % 3 == 0) begin
                        iv[s] = 1'b1; imem[s] = 1'b1; itid[s*TW +: TW] = TW'(t);
                    end else if (avail[t] > 0) begin
                        iv[s] = 1'b1; itid[s*TW +: TW] = TW'(t); avail[t]--;
                    end
                end
            end
            begin
                int t;
                t = int'($urandom % NT);
                if ($urandom % 3 == 0 && avail[t] > 0) begin
                    cv = 1'b1; ctid = TW'(t); avail[t]--;
                end
                t = int'($urandom % NT);
                if ($urandom % 8 == 0 && avail[t] > 0) begin
                    sv = 1'b1; stid = TW'(t); scnt = CW'(1 + $urandom % avail[t]);
                end
            end
            tick("R12");
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule